// File: doc/BRIEF.md
# Bang-Bang Square-Wave Phase Tracker

This block produces a square wave that follows the frequency and phase of an incoming square wave. A phase accumulator grows by a tuning word on every update tick, and its most significant bit is the synthesized output. Each time the input changes level, the block compares that change with the current level of the synthesized wave. It then raises or lowers the tuning word by a programmable gain step. Over time the tuning word settles near the input frequency, measured in accumulator units per tick, and it can be read as a frequency estimate.

The block also watches how far the accumulator is from the nearest half-cycle boundary at each input change. It reports lock after a programmable run of consecutive input changes whose distance is under a threshold. The tuning word is kept inside a programmable window so that it cannot wrap. The start value, gain, window, threshold and run length are all inputs. The input is assumed to be already synchronous to the clock, and the update tick is a one-cycle enable that comes from outside the block.

Top module: `sqpll_top`

## Requirements
- R1: During reset (rst_n low at a clock edge) the tuning word loads init_delta, the accumulator and the lock run counter clear to 0, lock_o goes to 0 and the stored previous input level becomes 0. After reset, synth_o is 0 and delta_o equals init_delta.
- R2: At a clock edge with tick_i high, the accumulator (ACC_W bits, wrapping modulo 2^ACC_W) adds the tuning word held before that edge. With tick_i low it holds. synth_o is accumulator bit ACC_W-1.
- R3: A rising input event is a clock edge where sig_i is 1 and the previously sampled level was 0. At that edge the tuning word increases by gain_i when synth_o is 0, and decreases by gain_i when synth_o is 1. With no event the tuning word holds.
- R4: A falling input event is a clock edge where sig_i is 0 and the previously sampled level was 1. At that edge the tuning word decreases by gain_i when synth_o is 0, and increases by gain_i when synth_o is 1.
- R5: An increase that would go above delta_max_i yields exactly delta_max_i. A decrease that would go below delta_min_i yields exactly delta_min_i.
- R6: At each input event the phase error is min(L, 2^(ACC_W-1) - L). Here L is the value of the low ACC_W-1 accumulator bits held before that edge.
- R7: At an event with phase error below thresh_i, the run counter increments, saturating at its maximum, and lock_o becomes 1 exactly when the new count is at least lock_len_i. At an event with error at or above thresh_i, the counter clears and lock_o drops. Cycles without an event leave lock_o unchanged.
- R8: With an input of constant period P clock cycles and tick_i always high, the tuning word, averaged over many periods, settles within 1/8 of 2^ACC_W / P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Accumulator update enable |
| sig_i | input | 1 | Synchronous input square wave |
| init_delta_i | input | DELTA_W | Tuning word loaded at reset |
| gain_i | input | DELTA_W | Correction step per input event |
| delta_min_i | input | DELTA_W | Lower limit of the tuning word |
| delta_max_i | input | DELTA_W | Upper limit of the tuning word |
| thresh_i | input | ACC_W-1 | Phase error threshold for lock |
| lock_len_i | input | CNT_W | Consecutive good events needed for lock |
| synth_o | output | 1 | Synthesized square wave |
| delta_o | output | DELTA_W | Current tuning word (frequency estimate) |
| lock_o | output | 1 | Lock indication |

## Verification
An input change or a tick that is applied before a clock edge acts at that same edge. The tuning word, accumulator, synthesized bit and lock flag are all registered, so each result can be seen one clock edge after its stimulus. No result takes more than one edge. The bench drives inputs just after a falling edge and steps a reference model from the same inputs. It then compares all three outputs at the next falling edge, which is one edge later. The settling check averages the tuning word over a long window of constant-period input instead of testing a single cycle.

// File: rtl/sqpll_pkg.sv
// Shared types for the square-wave phase tracker.
package sqpll_pkg;
    // Kind of input transition seen in the current cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } sq_event_e;
endpackage

// File: rtl/sqpll_edge_det.sv
// Input transition detector.
// Assumes sig_i is already synchronous to clk. The stored level resets to 0,
// so a high input in the first cycle after reset reads as a rising event.
module sqpll_edge_det
    import sqpll_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_i,
    output sq_event_e ev_o
);
    logic sig_q;

    // Keep the level sampled at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    // Classify the current cycle against the stored level
    always_comb begin
        if (sig_i && !sig_q)      ev_o = EV_RISE;
        else if (!sig_i && sig_q) ev_o = EV_FALL;
        else                      ev_o = EV_NONE;
    end
endmodule

// File: rtl/sqpll_delta_ctrl.sv
// Tuning word register with bang-bang correction and window clamping.
// Assumes delta_min_i <= delta_max_i. The reset value is taken from
// init_delta_i while reset is held.
module sqpll_delta_ctrl
    import sqpll_pkg::*;
#(
    parameter int DELTA_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sq_event_e          ev_i,
    input  logic               synth_i,
    input  logic [DELTA_W-1:0] init_delta_i,
    input  logic [DELTA_W-1:0] gain_i,
    input  logic [DELTA_W-1:0] delta_min_i,
    input  logic [DELTA_W-1:0] delta_max_i,
    output logic [DELTA_W-1:0] delta_o
);
    localparam int WIDE_W = DELTA_W + 1;

    logic               go_up;
    logic [WIDE_W-1:0]  sum_wide;
    logic [WIDE_W-1:0]  floor_wide;
    logic [DELTA_W-1:0] up_val;
    logic [DELTA_W-1:0] dn_val;
    logic [DELTA_W-1:0] delta_q;

    // Direction: speed up when the synthesized bit lags the input change
    always_comb begin
        go_up = ((ev_i == EV_RISE) && !synth_i) || ((ev_i == EV_FALL) && synth_i);
    end

    // Saturating step in either direction, in one bit wider arithmetic
    always_comb begin
        sum_wide   = {1'b0, delta_q} + {1'b0, gain_i};
        floor_wide = {1'b0, delta_min_i} + {1'b0, gain_i};
        up_val     = (sum_wide > {1'b0, delta_max_i}) ? delta_max_i : sum_wide[DELTA_W-1:0];
        dn_val     = ({1'b0, delta_q} < floor_wide) ? delta_min_i : (delta_q - gain_i);
    end

    // Update the tuning word on input events only
    always_ff @(posedge clk) begin
        if (!rst_n)               delta_q <= init_delta_i;
        else if (ev_i != EV_NONE) delta_q <= go_up ? up_val : dn_val;
    end

    assign delta_o = delta_q;
endmodule

// File: rtl/sqpll_phase_acc.sv
// Phase accumulator producing the synthesized square wave from its top bit.
// Assumes DELTA_W <= ACC_W; the tuning word is zero-extended.
module sqpll_phase_acc #(
    parameter int ACC_W   = 16,
    parameter int DELTA_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [DELTA_W-1:0] delta_i,
    output logic [ACC_W-1:0]   acc_o,
    output logic               synth_o
);
    localparam int PAD_W = ACC_W - DELTA_W;

    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] acc_q;

    // Widen the tuning word to accumulator width
    generate
        if (PAD_W > 0) begin : g_pad
            assign step = {{PAD_W{1'b0}}, delta_i};
        end else begin : g_nopad
            assign step = delta_i;
        end
    endgenerate

    // Advance phase on each tick, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (tick_i) acc_q <= acc_q + step;
    end

    assign acc_o   = acc_q;
    assign synth_o = acc_q[ACC_W-1];
endmodule

// File: rtl/sqpll_lock_det.sv
// Lock detector: measures distance to the nearest half-cycle boundary at
// each input event and counts consecutive events under the threshold.
// Assumes the counter width is enough for the largest lock length in use.
module sqpll_lock_det #(
    parameter int ACC_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-2:0] thresh_i,
    input  logic [CNT_W-1:0] lock_len_i,
    output logic [ACC_W-2:0] err_o,
    output logic             lock_o
);
    localparam int ERR_W = ACC_W - 1;

    logic [ERR_W-1:0] low_bits;
    logic [ERR_W:0]   mirror;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   run_next;
    logic             lock_q;

    // Distance to the closer of the two half-cycle boundaries
    always_comb begin
        low_bits = acc_i[ERR_W-1:0];
        mirror   = (ERR_W + 1)'(1 << ERR_W) - {1'b0, low_bits};
        err_o    = ({1'b0, low_bits} < mirror) ? low_bits : mirror[ERR_W-1:0];
    end

    // Saturating next run length
    always_comb begin
        run_next = (&run_q) ? {1'b0, run_q} : ({1'b0, run_q} + 1'b1);
    end

    // Track the run and the lock flag at input events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (ev_valid_i) begin
            if (err_o < thresh_i) begin
                run_q  <= run_next[CNT_W-1:0];
                lock_q <= (run_next >= {1'b0, lock_len_i});
            end else begin
                run_q  <= '0;
                lock_q <= 1'b0;
            end
        end
    end

    assign lock_o = lock_q;
endmodule

// File: rtl/sqpll_top.sv
// Square-wave phase tracker top level.
// Connects edge detection, tuning word control, phase accumulation and lock
// detection. Assumes sig_i is synchronous and tick_i is a one-cycle enable.
module sqpll_top
    import sqpll_pkg::*;
#(
    parameter int ACC_W   = 16,
    parameter int DELTA_W = 12,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               sig_i,
    input  logic [DELTA_W-1:0] init_delta_i,
    input  logic [DELTA_W-1:0] gain_i,
    input  logic [DELTA_W-1:0] delta_min_i,
    input  logic [DELTA_W-1:0] delta_max_i,
    input  logic [ACC_W-2:0]   thresh_i,
    input  logic [CNT_W-1:0]   lock_len_i,
    output logic               synth_o,
    output logic [DELTA_W-1:0] delta_o,
    output logic               lock_o
);
    sq_event_e          ev;
    logic [ACC_W-1:0]   acc;
    logic [ACC_W-2:0]   phase_err;
    logic [DELTA_W-1:0] delta;
    logic               synth;

    sqpll_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (sig_i),
        .ev_o  (ev)
    );

    sqpll_delta_ctrl #(.DELTA_W(DELTA_W)) u_delta (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_i         (ev),
        .synth_i      (synth),
        .init_delta_i (init_delta_i),
        .gain_i       (gain_i),
        .delta_min_i  (delta_min_i),
        .delta_max_i  (delta_max_i),
        .delta_o      (delta)
    );

    sqpll_phase_acc #(.ACC_W(ACC_W), .DELTA_W(DELTA_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .delta_i (delta),
        .acc_o   (acc),
        .synth_o (synth)
    );

    sqpll_lock_det #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid_i (ev != EV_NONE),
        .acc_i      (acc),
        .thresh_i   (thresh_i),
        .lock_len_i (lock_len_i),
        .err_o      (phase_err),
        .lock_o     (lock_o)
    );

    assign synth_o = synth;
    assign delta_o = delta;
endmodule

// File: rtl/sqpll_checker.sv
// Property checker for the square-wave phase tracker, attached by bind.
module sqpll_checker
    import sqpll_pkg::*;
#(
    parameter int ACC_W   = 16,
    parameter int DELTA_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input sq_event_e          ev,
    input logic [ACC_W-2:0]   phase_err,
    input logic [ACC_W-2:0]   thresh_i,
    input logic [DELTA_W-1:0] delta_max_i,
    input logic               synth_o,
    input logic [DELTA_W-1:0] delta_o,
    input logic               lock_o
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!lock_o && !synth_o));

    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(synth_o));

    // R3
    delta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_NONE) |=> $stable(delta_o));

    // R5
    up_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((ev == EV_RISE) && !synth_o) || ((ev == EV_FALL) && synth_o))
        |=> (delta_o <= $past(delta_max_i)));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_NONE) |=> $stable(lock_o));

    // R7
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev != EV_NONE) && (phase_err >= thresh_i)) |=> !lock_o);

    // R6
    err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err <= (ACC_W-1)'(1 << (ACC_W-2)));
endmodule

bind sqpll_top sqpll_checker #(.ACC_W(ACC_W), .DELTA_W(DELTA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .ev          (ev),
    .phase_err   (phase_err),
    .thresh_i    (thresh_i),
    .delta_max_i (delta_max_i),
    .synth_o     (synth_o),
    .delta_o     (delta_o),
    .lock_o      (lock_o)
);

// File: tb/sqpll_top_tb.sv
module sqpll_top_tb_top;
    localparam int ACC_W   = 16;
    localparam int DELTA_W = 12;
    localparam int CNT_W   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tick_i = 1'b0;
    logic               sig_i = 1'b0;
    logic [DELTA_W-1:0] init_delta_i = 12'd500;
    logic [DELTA_W-1:0] gain_i = 12'd8;
    logic [DELTA_W-1:0] delta_min_i = 12'd0;
    logic [DELTA_W-1:0] delta_max_i = 12'd4095;
    logic [ACC_W-2:0]   thresh_i = 15'd2048;
    logic [CNT_W-1:0]   lock_len_i = 8'd4;
    logic               synth_o;
    logic [DELTA_W-1:0] delta_o;
    logic               lock_o;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [ACC_W-1:0] m_acc;
    int               m_delta;
    logic             m_prev;
    int               m_run;
    logic             m_lock;
    string            m_dtag;

    always #4 clk = ~clk;

    sqpll_top #(.ACC_W(ACC_W), .DELTA_W(DELTA_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sig_i(sig_i),
        .init_delta_i(init_delta_i), .gain_i(gain_i),
        .delta_min_i(delta_min_i), .delta_max_i(delta_max_i),
        .thresh_i(thresh_i), .lock_len_i(lock_len_i),
        .synth_o(synth_o), .delta_o(delta_o), .lock_o(lock_o)
    );

    // R6 distance to nearest half-cycle boundary
    function automatic int phase_err(input logic [ACC_W-1:0] a);
        int lo;
        lo = int'(a[ACC_W-2:0]);
        return (lo < (1 << (ACC_W-1)) - lo) ? lo : (1 << (ACC_W-1)) - lo;
    endfunction

    function automatic int step_up(input int d);
        int s;
        s = d + int'(gain_i);
        return (s > int'(delta_max_i)) ? int'(delta_max_i) : s;
    endfunction

    function automatic int step_dn(input int d);
        int s;
        s = d - int'(gain_i);
        return (s < int'(delta_min_i)) ? int'(delta_min_i) : s;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, compare one edge later
    task automatic step(input logic t, input logic s);
        logic rise, fall, up;
        int   nd;
        tick_i = t;
        sig_i  = s;
        rise = s && !m_prev;
        fall = !s && m_prev;
        nd = m_delta;
        m_dtag = "R3";
        if (rise || fall) begin
            up = (rise && !m_acc[ACC_W-1]) || (fall && m_acc[ACC_W-1]);
            m_dtag = rise ? "R3" : "R4";
            if (up) begin
                nd = step_up(m_delta);
                if (m_delta + int'(gain_i) > int'(delta_max_i)) m_dtag = "R5";
            end else begin
                nd = step_dn(m_delta);
                if (m_delta - int'(gain_i) < int'(delta_min_i)) m_dtag = "R5";
            end
            if (phase_err(m_acc) < int'(thresh_i)) begin
                if (m_run < 255) m_run++;
                m_lock = (m_run >= int'(lock_len_i));
            end else begin
                m_run  = 0;
                m_lock = 1'b0;
            end
        end
        if (t) m_acc = m_acc + ACC_W'(m_delta);
        m_delta = nd;
        m_prev  = s;
        @(posedge clk);
        @(negedge clk);
        check("R2", "synth_o", int'(synth_o), int'(m_acc[ACC_W-1]));
        check(m_dtag, "delta_o", int'(delta_o), m_delta);
        check("R6/R7", "lock_o", int'(lock_o), int'(m_lock));
    endtask

    task automatic do_reset(input logic [DELTA_W-1:0] init);
        init_delta_i = init;
        rst_n  = 1'b0;
        tick_i = 1'b0;
        sig_i  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_acc = '0; m_delta = int'(init); m_prev = 1'b0; m_run = 0; m_lock = 1'b0;
        check("R1", "reset synth_o", int'(synth_o), 0);
        check("R1", "reset delta_o", int'(delta_o), int'(init));
        check("R1", "reset lock_o", int'(lock_o), 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic lvl;
        int   half, cnt;
        longint acc_sum;
        void'($urandom(32'd24681));
        @(negedge clk);
        do_reset(12'd500);

        // Directed: first cycle high input is a rising event (R3), tick held low (R2)
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);   // falling event, R4
        // Directed: ceiling clamp R5
        delta_max_i = 12'd505;
        gain_i = 12'd40;
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        // Directed: floor clamp R5
        delta_min_i = 12'd480;
        step(1'b1, 1'b1);
        for (int i = 0; i < 40; i++) step(1'b1, 1'(i % 2));

        // Second reset with a different start value (R1)
        delta_min_i = 12'd0;
        delta_max_i = 12'd4095;
        do_reset(12'd1234);

        // Random segments
        lvl = 1'b0;
        for (int seg = 0; seg < 40; seg++) begin
            gain_i      = DELTA_W'(1 + $urandom_range(0, 63));
            delta_min_i = DELTA_W'($urandom_range(0, 1500));
            delta_max_i = delta_min_i + DELTA_W'($urandom_range(200, 2500));
            thresh_i    = (ACC_W-1)'($urandom_range(0, 16383));
            lock_len_i  = CNT_W'($urandom_range(1, 8));
            half        = int'($urandom_range(3, 80));
            cnt = 0;
            for (int i = 0; i < 500; i++) begin
                cnt++;
                if (cnt >= half + int'($urandom_range(0, 2))) begin
                    cnt = 0;
                    lvl = ~lvl;
                end
                step(($urandom_range(0, 3) != 0), lvl);
            end
        end

        // Settling: period 64 cycles, tick always high (R8)
        do_reset(12'd1000);
        gain_i = 12'd1; delta_min_i = 12'd0; delta_max_i = 12'd4095;
        thresh_i = 15'd2048; lock_len_i = 8'd4;
        for (int p = 0; p < 200; p++)
            for (int i = 0; i < 64; i++) step(1'b1, (i < 32));
        acc_sum = 0;
        for (int p = 0; p < 200; p++)
            for (int i = 0; i < 64; i++) begin
                step(1'b1, (i < 32));
                acc_sum += longint'(delta_o);
            end
        acc_sum = acc_sum / (200 * 64);
        checks++;
        if (acc_sum < 1024 - 128 || acc_sum > 1024 + 128) begin
            fails++;
            $display("FAIL R8 mean delta actual=%0d expected=1024 +/-128", acc_sum);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule